// File: doc/BRIEF.md
# NAND Interface Timing Calculator

This block turns the timing limits of an asynchronous NAND flash device, all given in picoseconds, into the settings a flash controller needs. One start pulse latches every input. The block then picks a speed mode from the read-cycle limit, which fixes the controller clock rate, the clock period and the write-strobe delay code. From that period it derives the cycle counts for address setup, data setup and data hold. It also derives a busy-timeout field and a read-sample delay factor for the delay line that samples read data. The last step also tells whether the delay line runs on a half-period reference.

All divisions share one restoring divider, which produces one quotient bit per clock. A full computation therefore takes a few hundred cycles. Software or a sequencer starts a computation when the device timing mode changes and waits for the done pulse. Results stay on the outputs until the next computation finishes.

Top module: `nand_timing_calc`

## Requirements
- R1: The speed mode is chosen from the read-cycle limit. At 30000 ps or more: `clk_sel_o`=0 (22 MHz) and `wr_dly_o`=1 (4 to 8 ns write delay). From 25000 to 29999 ps: `clk_sel_o`=1 (80 MHz) and `wr_dly_o`=0. Below 25000 ps: `clk_sel_o`=2 (100 MHz) and `wr_dly_o`=0.
- R2: The period in ps is 10^12 divided by the clock rate, truncated: 45454, 12500 or 10000. The address-setup, data-setup and data-hold outputs are ceil(t/period) for their own limit, kept to the low 16 bits. A zero limit gives zero cycles.
- R3: `busy_tmo_o` equals (ceil((tWB+tR)/period) mod 65536) * 4096. The count therefore sits in bits 27:12 and bits 11:0 are zero.
- R4: The half-period reference applies only when the period is strictly greater than the delay-line threshold. The reference period is then period/2, truncated. Otherwise it is the full period, including when the two are equal.
- R5: The sample delay is (tREA + 4000 - data_setup_cycles*period)*8, signed. When it is positive, `rd_sample_o` equals sample_delay / reference_period, truncated. Otherwise `rd_sample_o` is 0.
- R6: `dll_en_o` is 1 exactly when `rd_sample_o` is nonzero. `half_per_o` is 1 only when the half-period reference applies and `rd_sample_o` is nonzero.
- R7: All outputs update together on one clock edge. `done_o` is a one-cycle pulse in the cycle after that update. Between updates every output holds its value.
- R8: A start pulse that arrives while a computation is running is ignored, together with any input changes that come with it. The running computation finishes with the values latched at its own start.
- R9: While reset is high and after it is released, every output reads 0 until the first computation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; latches all timing inputs |
| trc_min_i | input | 32 | Minimum read cycle time, ps |
| tals_min_i | input | 32 | Minimum address-latch setup, ps |
| tds_min_i | input | 32 | Minimum data setup, ps |
| tdh_min_i | input | 32 | Minimum data hold, ps |
| twb_max_i | input | 32 | Maximum write-to-busy time, ps |
| tr_max_i | input | 32 | Maximum array read time, ps |
| trea_max_i | input | 32 | Maximum read access time, ps |
| dll_thresh_i | input | 32 | Delay-line period threshold, ps |
| clk_sel_o | output | 2 | Clock rate select: 0=22, 1=80, 2=100 MHz |
| wr_dly_o | output | 2 | Write-strobe delay code: 1=4 to 8 ns, 0=none |
| addr_setup_o | output | 16 | Address-setup cycles |
| data_setup_o | output | 16 | Data-setup cycles |
| data_hold_o | output | 16 | Data-hold cycles |
| busy_tmo_o | output | 28 | Busy-timeout field (count shifted left by 12) |
| rd_sample_o | output | 32 | Read-sample delay factor |
| dll_en_o | output | 1 | Delay line enable |
| half_per_o | output | 1 | Half-period reference flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps the read-cycle limit across both mode boundaries: 24999/25000, 29999/30000, and values well inside each mode. For each limit it runs eight timing sets. Those sets include a zero hold time, a data setup of one picosecond, and a threshold equal to the mid-mode period, which separates the strict from the inclusive comparison. Some sets have a read access time that gives a negative sample delay, others give positive delays with and without the half-period reference, so truncation, the zero clamp and the flag gating are told apart. One set has an array read time large enough that the busy count wraps at 16 bits. A start pulse with altered inputs injected mid-run shows whether the block relatches while busy.

// File: rtl/nt_pkg.sv
package nt_pkg;
  typedef enum logic [1:0] {
    SPD_SLOW = 2'd0,
    SPD_MID  = 2'd1,
    SPD_FAST = 2'd2
  } spd_e;

  localparam logic [1:0] WDLY_NONE = 2'd0;
  localparam logic [1:0] WDLY_4TO8 = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALS,
    ST_DS,
    ST_DH,
    ST_BSY,
    ST_RDN,
    ST_COMMIT,
    ST_FIN
  } st_e;
endpackage

// File: rtl/nt_speed_sel.sv
module nt_speed_sel
  import nt_pkg::*;
#(
  parameter int     TW       = 32,
  parameter int     PER_W    = 16,
  parameter int     SLOW_LIM = 30000,
  parameter int     MID_LIM  = 25000,
  parameter longint SLOW_HZ  = 22000000,
  parameter longint MID_HZ   = 80000000,
  parameter longint FAST_HZ  = 100000000
) (
  input  logic [TW-1:0]    trc_i,
  output spd_e             sel_o,
  output logic [1:0]       wdly_o,
  output logic [PER_W-1:0] per_o
);
  localparam longint PS_PER_SEC = 64'd1000000000000;
  localparam logic [PER_W-1:0] PER_SLOW = PER_W'(PS_PER_SEC / SLOW_HZ);
  localparam logic [PER_W-1:0] PER_MID  = PER_W'(PS_PER_SEC / MID_HZ);
  localparam logic [PER_W-1:0] PER_FAST = PER_W'(PS_PER_SEC / FAST_HZ);

  always_comb begin
    if (trc_i >= TW'(SLOW_LIM)) begin
      sel_o  = SPD_SLOW;
      wdly_o = WDLY_4TO8;
      per_o  = PER_SLOW;
    end else if (trc_i >= TW'(MID_LIM)) begin
      sel_o  = SPD_MID;
      wdly_o = WDLY_NONE;
      per_o  = PER_MID;
    end else begin
      sel_o  = SPD_FAST;
      wdly_o = WDLY_NONE;
      per_o  = PER_FAST;
    end
  end
endmodule

// File: rtl/nt_divider.sv
module nt_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  // one restoring step: bring down the next dividend bit and try a subtract
  assign shifted = {rem_q, quo_o[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_o  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quo_o <= dvd_i;
        dvs_q <= dvs_i;
        rem_q <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (trial[W]) begin
          rem_q <= shifted[W-1:0];
          quo_o <= {quo_o[W-2:0], 1'b0};
        end else begin
          rem_q <= trial[W-1:0];
          quo_o <= {quo_o[W-2:0], 1'b1};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nand_timing_calc.sv
module nand_timing_calc
  import nt_pkg::*;
#(
  parameter int TW        = 32,
  parameter int CNT_W     = 16,
  parameter int BUSY_W    = 16,
  parameter int BUSY_SH   = 12,
  parameter int PER_W     = 16,
  parameter int MARGIN_PS = 4000,
  parameter int SCALE_SH  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [TW-1:0]             trc_min_i,
  input  logic [TW-1:0]             tals_min_i,
  input  logic [TW-1:0]             tds_min_i,
  input  logic [TW-1:0]             tdh_min_i,
  input  logic [TW-1:0]             twb_max_i,
  input  logic [TW-1:0]             tr_max_i,
  input  logic [TW-1:0]             trea_max_i,
  input  logic [TW-1:0]             dll_thresh_i,
  output logic [1:0]                clk_sel_o,
  output logic [1:0]                wr_dly_o,
  output logic [CNT_W-1:0]          addr_setup_o,
  output logic [CNT_W-1:0]          data_setup_o,
  output logic [CNT_W-1:0]          data_hold_o,
  output logic [BUSY_W+BUSY_SH-1:0] busy_tmo_o,
  output logic [TW-1:0]             rd_sample_o,
  output logic                      dll_en_o,
  output logic                      half_per_o,
  output logic                      done_o
);
  localparam int SDW = 2 * TW;

  st_e              state;
  spd_e             sel_w, sel_q;
  logic [1:0]       wdly_w, wdly_q;
  logic [PER_W-1:0] per_w, per_q;
  logic [TW-1:0]    tals_q, tds_q, tdh_q, tsum_q, trea_q, thr_q;
  logic [CNT_W-1:0] als_q, ds_q, dh_q;
  logic [BUSY_W-1:0] bsy_q;
  logic [TW-1:0]    fac_q;
  logic             div_go, div_done;
  logic [TW-1:0]    dvd, dvs, div_q;
  logic [TW-1:0]    per32, refp;
  logic             per_gt;
  logic [SDW-1:0]   trp, sdly;
  logic             sd_pos;

  nt_speed_sel #(.TW(TW), .PER_W(PER_W)) u_spd (
    .trc_i  (trc_min_i),
    .sel_o  (sel_w),
    .wdly_o (wdly_w),
    .per_o  (per_w)
  );

  nt_divider #(.W(TW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (div_go),
    .dvd_i   (dvd),
    .dvs_i   (dvs),
    .quo_o   (div_q),
    .done_o  (div_done)
  );

  assign per32  = TW'(per_q);
  assign per_gt = per32 > thr_q;
  assign refp   = per_gt ? (per32 >> 1) : per32;
  assign trp    = SDW'(ds_q) * SDW'(per_q);
  assign sdly   = (SDW'(trea_q) + SDW'(MARGIN_PS) - trp) << SCALE_SH;
  assign sd_pos = !sdly[SDW-1] && (sdly != '0);

  // operands for the shared divider, picked by the current step
  always_comb begin
    dvs = per32;
    unique case (state)
      ST_ALS:  dvd = tals_q + per32 - 1'b1;
      ST_DS:   dvd = tds_q + per32 - 1'b1;
      ST_DH:   dvd = tdh_q + per32 - 1'b1;
      ST_BSY:  dvd = tsum_q + per32 - 1'b1;
      ST_RDN: begin
        dvd = sdly[TW-1:0];
        dvs = refp;
      end
      default: dvd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      div_go       <= 1'b0;
      done_o       <= 1'b0;
      sel_q        <= SPD_SLOW;
      wdly_q       <= '0;
      per_q        <= '0;
      tals_q       <= '0;
      tds_q        <= '0;
      tdh_q        <= '0;
      tsum_q       <= '0;
      trea_q       <= '0;
      thr_q        <= '0;
      als_q        <= '0;
      ds_q         <= '0;
      dh_q         <= '0;
      bsy_q        <= '0;
      fac_q        <= '0;
      clk_sel_o    <= '0;
      wr_dly_o     <= '0;
      addr_setup_o <= '0;
      data_setup_o <= '0;
      data_hold_o  <= '0;
      busy_tmo_o   <= '0;
      rd_sample_o  <= '0;
      dll_en_o     <= 1'b0;
      half_per_o   <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          sel_q  <= sel_w;
          wdly_q <= wdly_w;
          per_q  <= per_w;
          tals_q <= tals_min_i;
          tds_q  <= tds_min_i;
          tdh_q  <= tdh_min_i;
          tsum_q <= twb_max_i + tr_max_i;
          trea_q <= trea_max_i;
          thr_q  <= dll_thresh_i;
          div_go <= 1'b1;
          state  <= ST_ALS;
        end
        ST_ALS: if (div_done) begin
          als_q  <= CNT_W'(div_q);
          div_go <= 1'b1;
          state  <= ST_DS;
        end
        ST_DS: if (div_done) begin
          ds_q   <= CNT_W'(div_q);
          div_go <= 1'b1;
          state  <= ST_DH;
        end
        ST_DH: if (div_done) begin
          dh_q   <= CNT_W'(div_q);
          div_go <= 1'b1;
          state  <= ST_BSY;
        end
        ST_BSY: if (div_done) begin
          bsy_q <= BUSY_W'(div_q);
          if (sd_pos) begin
            div_go <= 1'b1;
            state  <= ST_RDN;
          end else begin
            fac_q <= '0;
            state <= ST_COMMIT;
          end
        end
        ST_RDN: if (div_done) begin
          fac_q <= div_q;
          state <= ST_COMMIT;
        end
        ST_COMMIT: begin
          clk_sel_o    <= sel_q;
          wr_dly_o     <= wdly_q;
          addr_setup_o <= als_q;
          data_setup_o <= ds_q;
          data_hold_o  <= dh_q;
          busy_tmo_o   <= {bsy_q, {BUSY_SH{1'b0}}};
          rd_sample_o  <= fac_q;
          dll_en_o     <= fac_q != '0;
          half_per_o   <= per_gt && (fac_q != '0);
          state        <= ST_FIN;
        end
        ST_FIN: begin
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_timing_calc_chk.sv
module nand_timing_calc_chk #(
  parameter int TW     = 32,
  parameter int CNT_W  = 16,
  parameter int BW     = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             done_o,
  input logic [1:0]       clk_sel_o,
  input logic [1:0]       wr_dly_o,
  input logic [CNT_W-1:0] addr_setup_o,
  input logic [CNT_W-1:0] data_setup_o,
  input logic [CNT_W-1:0] data_hold_o,
  input logic [BW-1:0]    busy_tmo_o,
  input logic [TW-1:0]    rd_sample_o,
  input logic             dll_en_o,
  input logic             half_per_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({clk_sel_o, wr_dly_o, addr_setup_o, data_setup_o, data_hold_o,
              busy_tmo_o, rd_sample_o, dll_en_o, half_per_o}) |=> done_o);

  // R6
  half_needs_dll_chk: assert property (@(posedge clk) disable iff (rst)
    half_per_o |-> dll_en_o);

  // R6
  dll_factor_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (dll_en_o == (rd_sample_o != '0)));

  // R1
  mode_code_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (clk_sel_o != 2'd3) && ((wr_dly_o == 2'd1) == (clk_sel_o == 2'd0)));
endmodule

bind nand_timing_calc nand_timing_calc_chk #(
  .TW(TW), .CNT_W(CNT_W), .BW(BUSY_W + BUSY_SH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .done_o       (done_o),
  .clk_sel_o    (clk_sel_o),
  .wr_dly_o     (wr_dly_o),
  .addr_setup_o (addr_setup_o),
  .data_setup_o (data_setup_o),
  .data_hold_o  (data_hold_o),
  .busy_tmo_o   (busy_tmo_o),
  .rd_sample_o  (rd_sample_o),
  .dll_en_o     (dll_en_o),
  .half_per_o   (half_per_o)
);

// File: tb/nand_timing_calc_test.sv
`timescale 1ns/1ps
module nand_timing_calc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] trc = '0, tals = '0, tds = '0, tdh = '0;
  logic [31:0] twb = '0, tr = '0, trea = '0, thr = '0;
  logic [1:0]  sel_o, wd_o;
  logic [15:0] als_o, ds_o, dh_o;
  logic [27:0] bsy_o;
  logic [31:0] fac_o;
  logic        dll_o, half_o, done;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nand_timing_calc uut (
    .clk(clk), .rst(rst), .start_i(start),
    .trc_min_i(trc), .tals_min_i(tals), .tds_min_i(tds), .tdh_min_i(tdh),
    .twb_max_i(twb), .tr_max_i(tr), .trea_max_i(trea), .dll_thresh_i(thr),
    .clk_sel_o(sel_o), .wr_dly_o(wd_o), .addr_setup_o(als_o),
    .data_setup_o(ds_o), .data_hold_o(dh_o), .busy_tmo_o(bsy_o),
    .rd_sample_o(fac_o), .dll_en_o(dll_o), .half_per_o(half_o), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [129:0] snap();
    return {sel_o, wd_o, als_o, ds_o, dh_o, bsy_o, fac_o, dll_o, half_o, 14'd0};
  endfunction

  task automatic run_case(input bit inject);
    logic [1:0] e_sel, e_wd;
    logic [15:0] e_als, e_ds, e_dh;
    logic [27:0] e_bsy;
    logic [31:0] e_fac;
    logic e_dll, e_half;
    longint p, r, c, sd, f;
    bit h, seen, pend, early;
    int waited;
    logic [129:0] prev, cur;
    // model from the requirements
    if (trc >= 30000) begin e_sel = 2'd0; e_wd = 2'd1; p = 64'd1000000000000 / 22000000; end
    else if (trc >= 25000) begin e_sel = 2'd1; e_wd = 2'd0; p = 64'd1000000000000 / 80000000; end
    else begin e_sel = 2'd2; e_wd = 2'd0; p = 64'd1000000000000 / 100000000; end
    e_als = 16'((longint'(tals) + p - 1) / p);
    e_ds  = 16'((longint'(tds) + p - 1) / p);
    e_dh  = 16'((longint'(tdh) + p - 1) / p);
    c = (longint'(twb) + longint'(tr) + p - 1) / p;
    e_bsy = 28'((c % 65536) * 4096);
    h = p > longint'(thr);
    r = h ? p / 2 : p;
    sd = (longint'(trea) + 4000 - longint'(e_ds) * p) * 8;
    f = (sd > 0) ? sd / r : 0;
    e_fac = 32'(f);
    e_dll = (f != 0);
    e_half = h && (f != 0);

    prev = snap();
    pend = 0; early = 0; seen = 0; waited = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!seen && waited < 1000) begin
      if (inject && waited == 20) begin
        start = 1'b1;
        trc = 32'd5000; tds = 32'd1; trea = 32'd90000; thr = 32'd1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
      cur = snap();
      if (done) seen = 1;
      else begin
        if (pend) early = 1;
        pend = (cur != prev);
      end
      prev = cur;
    end
    start = 1'b0;
    if (!seen) begin
      chk(0, "R7 watchdog: no done pulse", 0, 1);
      return;
    end
    chk(sel_o == e_sel, "R1 clk_sel", sel_o, e_sel);
    chk(wd_o == e_wd, "R1 write delay code", wd_o, e_wd);
    chk(als_o == e_als, "R2 addr setup", als_o, e_als);
    chk(ds_o == e_ds, "R2 data setup", ds_o, e_ds);
    chk(dh_o == e_dh, "R2 data hold", dh_o, e_dh);
    chk(bsy_o == e_bsy, "R3 busy field", bsy_o, e_bsy);
    chk(half_o == e_half, "R4 half period", half_o, e_half);
    chk(fac_o == e_fac, "R5 sample factor", fac_o, e_fac);
    chk(dll_o == e_dll, "R6 dll enable", dll_o, e_dll);
    chk(!early, "R7 outputs changed before the pre-done cycle", early, 0);
    if (inject) chk(fac_o == e_fac && ds_o == e_ds && sel_o == e_sel,
                    "R8 restart ignored", fac_o, e_fac);
    cur = snap();
    @(negedge clk);
    chk(done == 1'b0, "R7 done width", done, 0);
    repeat (4) @(negedge clk);
    chk(snap() == cur, "R7 outputs hold after done", 0, 0);
  endtask

  initial begin
    int trcs[6] = '{10000, 24999, 25000, 29999, 30000, 45000};
    int thrs[4] = '{12000, 12500, 16000, 50000};
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(snap() == '0 && done == 1'b0, "R9 outputs during reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(snap() == '0 && done == 1'b0, "R9 outputs after reset", 0, 0);
    for (int m = 0; m < 6; m++) begin
      for (int i = 0; i < 8; i++) begin
        trc  = trcs[m];
        tals = 500 + i * 2300;
        tds  = 1 + i * 4100;
        tdh  = i * 1700;
        twb  = 100000 + i;
        tr   = (i == 7) ? 32'd1000000000 : 32'(25000000 * i);
        trea = (i >= 6) ? 32'(90000 + i) : 32'(2000 + i * 3000);
        thr  = thrs[i % 4];
        run_case(1'b0);
      end
    end
    // R8: restart while busy, in two modes
    trc = 32'd26000; tals = 32'd7000; tds = 32'd9000; tdh = 32'd3000;
    twb = 32'd200000; tr = 32'd30000000; trea = 32'd40000; thr = 32'd16000;
    run_case(1'b1);
    trc = 32'd31000; tals = 32'd60000; tds = 32'd20000; tdh = 32'd5000;
    twb = 32'd100000; tr = 32'd50000000; trea = 32'd80000; thr = 32'd16000;
    run_case(1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule